// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Parity Check and Receive Status

This block receives asynchronous serial frames and turns them into parallel words. A 16x oversampling tick paces it, and that tick comes from a baud generator outside the block. Two control bits set the frame layout. The length select gives 8 or 9 payload bits. The parity enable turns the top payload bit into a parity bit, and an odd/even select sets which parity the check expects. The last complete frame stays in a 9-bit data register until the host reads it.

The block keeps four receive status flags: data-ready, overrun, idle line and parity error. A host read strobe clears all four. Each flag group has its own enable into one shared interrupt request. A freeze input stops reception and holds every register.

Top module: `uart_rx_status`

## Requirements
- R1: A frame is a low start bit, then N payload bits LSB first, then a stop bit. N is 8 when `len9`=0 and 9 when `len9`=1. Payload bit i lands in `rx_data[i]`, and `rx_data[8]` reads 0 when N is 8. With `par_en`=1 the top payload bit, `rx_data[N-1]`, holds the received parity bit instead of data.
- R2: With `par_en`=1, `par_err` is set when the count of ones over the N payload bits is odd while `par_odd`=0, or even while `par_odd`=1. With `par_en`=0, `par_err` is never set.
- R3: A falling line is taken as a start bit only if it is still low at the 8th oversampling tick. A shorter low pulse is ignored. A frame whose stop bit samples low is discarded and changes no flag or data.
- R4: `irq` is high exactly when `ie_rx` is set and `ready` or `overrun` is set, or `ie_idle` and `idle` are both set, or `ie_par` and `par_err` are both set.
- R5: When a frame completes while `ready` is still set, `overrun` sets. `rx_data` and `ready` keep the earlier frame, and the new frame is dropped.
- R6: A good frame with `ready` clear loads `rx_data` and sets `ready`.
- R7: A `rd_strobe` pulse clears `ready`, `overrun`, `idle` and `par_err`.
- R8: After a good frame, `idle` sets once the line has stayed high in the idle state for 16*(N+2) ticks. It sets only once per received frame.
- R9: While `freeze` is high, ticks and read strobes have no effect, and the data register and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Holds all state and stops reception |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len9 | input | 1 | 1 selects 9 payload bits, 0 selects 8 |
| par_en | input | 1 | Top payload bit is a parity bit |
| par_odd | input | 1 | 1 expects odd parity, 0 even |
| rd_strobe | input | 1 | Host read of the data register; clears the flags |
| ie_rx | input | 1 | Interrupt enable for data-ready and overrun |
| ie_idle | input | 1 | Interrupt enable for idle line |
| ie_par | input | 1 | Interrupt enable for parity error |
| rx_data | output | 9 | Received payload register |
| ready | output | 1 | Received data ready |
| overrun | output | 1 | Frame lost while data was unread |
| idle | output | 1 | Idle line detected |
| par_err | output | 1 | Parity mismatch on the held frame |
| irq | output | 1 | Shared interrupt request |

## Verification
On every cycle the assertions check four things: a read clears the flags, freeze holds the data register and the flags, an overrun leaves the held data untouched, and a parity error never appears with parity disabled. They also check that each interrupt source reaches `irq` through its enable. Only the bench scenarios can show the rest. That covers the bit order and where the parity bit lands in each of the four layouts, and the parity verdicts for both senses. It also covers start-glitch rejection, the discard on a bad stop bit, and when `idle` rises relative to the frame length.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2+1-1:0], din} >> 0;
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rxs_deser.sv
module rxs_deser
   import rxs_pkg::*;
#(
   parameter int OS_RATE  = 16,
   parameter int MAX_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                freeze,
   input  logic                tick,
   input  logic                rxd_s,
   input  logic                len9,
   output logic                done,
   output logic                stop_ok,
   output logic [MAX_BITS-1:0] word,
   output logic                in_idle
);
   localparam int CW = $clog2(OS_RATE);
   localparam int IW = $clog2(MAX_BITS + 1);
   localparam logic [CW-1:0] HALF = CW'(OS_RATE / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

   rx_state_t             state;
   logic [CW-1:0]         cnt;
   logic [IW-1:0]         bidx;
   logic [MAX_BITS-1:0]   sh;
   logic [IW-1:0]         nbits_m1;

   assign nbits_m1 = len9 ? IW'(MAX_BITS - 1) : IW'(MAX_BITS - 2);
   assign word     = len9 ? sh : (sh >> 1);
   assign in_idle  = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         sh      <= '0;
         done    <= 1'b0;
         stop_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!freeze && tick) begin
            case (state)
               ST_IDLE: begin
                  cnt <= '0;
                  if (!rxd_s) state <= ST_START;
               end
               ST_START: begin
                  if (cnt == HALF) begin
                     cnt   <= '0;
                     bidx  <= '0;
                     state <= rxd_s ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     sh  <= {rxd_s, sh[MAX_BITS-1:1]};
                     if (bidx == nbits_m1) state <= ST_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     done    <= 1'b1;
                     stop_ok <= rxd_s;
                     state   <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags #(
   parameter int OS_RATE  = 16,
   parameter int MAX_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                freeze,
   input  logic                tick,
   input  logic                rxd_s,
   input  logic                len9,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                rd_strobe,
   input  logic                done,
   input  logic                stop_ok,
   input  logic [MAX_BITS-1:0] word,
   input  logic                in_idle,
   output logic [MAX_BITS-1:0] data_q,
   output logic                ready_q,
   output logic                ovr_q,
   output logic                idle_q,
   output logic                perr_q
);
   localparam int FT_MAX = OS_RATE * (MAX_BITS + 2);
   localparam int FW     = $clog2(FT_MAX + 1);

   logic          good, rd, armed, line_quiet;
   logic [FW-1:0] qcnt, q_last;

   assign rd         = rd_strobe && !freeze;
   assign good       = done && stop_ok && !freeze;
   assign line_quiet = in_idle && rxd_s;
   assign q_last     = len9 ? FW'(FT_MAX - 1) : FW'(FT_MAX - OS_RATE - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         perr_q  <= 1'b0;
      end else if (good && (!ready_q || rd)) begin
         data_q  <= word;
         ready_q <= 1'b1;
         ovr_q   <= 1'b0;
         perr_q  <= par_en && ((^word) != par_odd);
      end else if (rd) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         perr_q  <= 1'b0;
      end else if (good) begin
         ovr_q   <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         qcnt   <= '0;
         idle_q <= 1'b0;
      end else if (!freeze) begin
         if (good) begin
            armed <= 1'b1;
            qcnt  <= '0;
         end else if (!line_quiet) begin
            qcnt <= '0;
         end else if (armed && tick) begin
            if (qcnt == q_last) begin
               armed  <= 1'b0;
               qcnt   <= '0;
               idle_q <= 1'b1;
            end else begin
               qcnt <= qcnt + 1'b1;
            end
         end
         if (rd) idle_q <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
   parameter int OS_RATE     = 16,
   parameter int MAX_BITS    = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                freeze,
   input  logic                os_tick,
   input  logic                rxd,
   input  logic                len9,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                rd_strobe,
   input  logic                ie_rx,
   input  logic                ie_idle,
   input  logic                ie_par,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                ready,
   output logic                overrun,
   output logic                idle,
   output logic                par_err,
   output logic                irq
);
   initial begin
      assert (OS_RATE >= 4 && (OS_RATE & (OS_RATE - 1)) == 0)
         else $error("OS_RATE must be a power of two of at least 4");
      assert (MAX_BITS >= 2) else $error("MAX_BITS must be at least 2");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
   end

   logic                rxd_s, done, stop_ok, in_idle;
   logic [MAX_BITS-1:0] word;

   rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
   );

   rxs_deser #(.OS_RATE(OS_RATE), .MAX_BITS(MAX_BITS)) u_deser (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .tick(os_tick),
      .rxd_s(rxd_s), .len9(len9), .done(done), .stop_ok(stop_ok),
      .word(word), .in_idle(in_idle)
   );

   rxs_flags #(.OS_RATE(OS_RATE), .MAX_BITS(MAX_BITS)) u_flags (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .tick(os_tick),
      .rxd_s(rxd_s), .len9(len9), .par_en(par_en), .par_odd(par_odd),
      .rd_strobe(rd_strobe), .done(done), .stop_ok(stop_ok), .word(word),
      .in_idle(in_idle), .data_q(rx_data), .ready_q(ready),
      .ovr_q(overrun), .idle_q(idle), .perr_q(par_err)
   );

   assign irq = (ie_rx && (ready || overrun)) || (ie_idle && idle) ||
                (ie_par && par_err);
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
   parameter int MAX_BITS = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                freeze,
   input logic                rd_strobe,
   input logic                par_en,
   input logic                ie_rx,
   input logic                ie_idle,
   input logic                ie_par,
   input logic [MAX_BITS-1:0] rx_data,
   input logic                ready,
   input logic                overrun,
   input logic                idle,
   input logic                par_err,
   input logic                irq
);
   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !freeze) |=> (!overrun && !idle))
      else $error("read did not clear flags");

   // R9
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> ($stable(rx_data) && $stable(ready) && $stable(overrun) &&
                  $stable(idle) && $stable(par_err)))
      else $error("state moved during freeze");

   // R5
   overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> ($stable(rx_data) && ready))
      else $error("overrun disturbed held data");

   // R2
   parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> $past(par_en))
      else $error("parity error with parity disabled");

   // R4
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_rx && !ie_idle && !ie_par) |-> !irq)
      else $error("irq with all enables clear");

   // R4
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ie_rx && ready) || (ie_idle && idle) || (ie_par && par_err)) |-> irq)
      else $error("enabled source did not raise irq");
endmodule

bind uart_rx_status uart_rx_status_chk #(.MAX_BITS(MAX_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .freeze(freeze), .rd_strobe(rd_strobe),
   .par_en(par_en), .ie_rx(ie_rx), .ie_idle(ie_idle), .ie_par(ie_par),
   .rx_data(rx_data), .ready(ready), .overrun(overrun), .idle(idle),
   .par_err(par_err), .irq(irq)
);

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;
   logic clk = 1'b0, rst_n = 1'b0, freeze = 1'b0, os_tick = 1'b0, rxd = 1'b1;
   logic len9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, rd_strobe = 1'b0;
   logic ie_rx = 1'b0, ie_idle = 1'b0, ie_par = 1'b0;
   logic [8:0] rx_data;
   logic ready, overrun, idle, par_err, irq;
   logic [1:0] div = '0;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      div     <= div + 1'b1;
      os_tick <= (div == 2'd3);
   end

   uart_rx_status u0 (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .os_tick(os_tick), .rxd(rxd),
      .len9(len9), .par_en(par_en), .par_odd(par_odd), .rd_strobe(rd_strobe),
      .ie_rx(ie_rx), .ie_idle(ie_idle), .ie_par(ie_par), .rx_data(rx_data),
      .ready(ready), .overrun(overrun), .idle(idle), .par_err(par_err), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         while (!os_tick) @(posedge clk);
      end
   endtask

   task automatic send(input logic [8:0] pay, input int nb, input logic stopv);
      @(negedge clk); rxd = 1'b0; wait_ticks(16);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk); rxd = pay[i]; wait_ticks(16);
      end
      @(negedge clk); rxd = stopv; wait_ticks(16);
      @(negedge clk); rxd = 1'b1; wait_ticks(2);
      @(negedge clk);
   endtask

   task automatic host_read();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   task automatic t_reset();
      chk("R6 reset ready", ready, 0);
      chk("R5 reset overrun", overrun, 0);
      chk("R4 reset irq", irq, 0);
      chk("R1 reset data", rx_data, 0);
   endtask

   task automatic t_plain8();
      len9 = 0; par_en = 0;
      send(9'h0A5, 8, 1'b1);
      chk("R1 8-bit data", rx_data, 'h0A5);
      chk("R6 ready set", ready, 1);
      chk("R2 no parity err", par_err, 0);
      chk("R4 irq off when ie_rx=0", irq, 0);
      @(negedge clk); ie_rx = 1; @(negedge clk);
      chk("R4 irq on ready", irq, 1);
      host_read();
      chk("R7 read clears ready", ready, 0);
      chk("R4 irq drops", irq, 0);
      ie_rx = 0;
   endtask

   task automatic t_plain9();
      len9 = 1; par_en = 0;
      send(9'h15A, 9, 1'b1);
      chk("R1 9-bit data", rx_data, 'h15A);
      chk("R6 ready 9-bit", ready, 1);
      host_read();
   endtask

   task automatic t_par7();
      len9 = 0; par_en = 1; par_odd = 0;
      send(9'h035, 8, 1'b1);
      chk("R1 parity bit in bit7", rx_data, 'h035);
      chk("R2 even ok", par_err, 0);
      host_read();
      send(9'h0B5, 8, 1'b1);
      chk("R2 even bad", par_err, 1);
      chk("R4 irq masked par", irq, 0);
      @(negedge clk); ie_par = 1; @(negedge clk);
      chk("R4 irq par", irq, 1);
      host_read();
      chk("R7 read clears par_err", par_err, 0);
      ie_par = 0;
   endtask

   task automatic t_par8odd();
      len9 = 1; par_en = 1; par_odd = 1;
      send(9'h135, 9, 1'b1);
      chk("R1 parity bit in bit8", rx_data, 'h135);
      chk("R2 odd ok", par_err, 0);
      host_read();
      send(9'h035, 9, 1'b1);
      chk("R2 odd bad", par_err, 1);
      host_read();
      par_en = 0; par_odd = 0;
   endtask

   task automatic t_overrun();
      len9 = 0;
      send(9'h011, 8, 1'b1);
      send(9'h022, 8, 1'b1);
      chk("R5 overrun set", overrun, 1);
      chk("R5 data kept", rx_data, 'h011);
      @(negedge clk); ie_rx = 1; @(negedge clk);
      chk("R4 irq overrun", irq, 1);
      host_read();
      chk("R7 read clears overrun", overrun, 0);
      ie_rx = 0;
   endtask

   task automatic t_idle();
      len9 = 0;
      send(9'h0C3, 8, 1'b1);
      host_read();
      wait_ticks(100);
      @(negedge clk);
      chk("R8 idle not early", idle, 0);
      wait_ticks(100);
      @(negedge clk);
      chk("R8 idle set", idle, 1);
      ie_idle = 1; @(negedge clk);
      chk("R4 irq idle", irq, 1);
      host_read();
      chk("R7 read clears idle", idle, 0);
      wait_ticks(250);
      @(negedge clk);
      chk("R8 idle once per frame", idle, 0);
      ie_idle = 0;
   endtask

   task automatic t_bad_frames();
      len9 = 0;
      @(negedge clk); rxd = 0; wait_ticks(4);
      @(negedge clk); rxd = 1; wait_ticks(40);
      @(negedge clk);
      chk("R3 glitch ignored", ready, 0);
      send(9'h05A, 8, 1'b0);
      wait_ticks(30);
      @(negedge clk);
      chk("R3 bad stop discarded", ready, 0);
      chk("R3 bad stop data", rx_data, 'h0C3);
   endtask

   task automatic t_freeze();
      len9 = 0;
      @(negedge clk); freeze = 1;
      send(9'h0F0, 8, 1'b1);
      @(negedge clk); freeze = 0;
      wait_ticks(20); @(negedge clk);
      chk("R9 no reception frozen", ready, 0);
      send(9'h00F, 8, 1'b1);
      @(negedge clk); freeze = 1;
      host_read();
      chk("R9 read ignored frozen", ready, 1);
      @(negedge clk); freeze = 0; @(negedge clk);
      chk("R9 data after freeze", rx_data, 'h00F);
      host_read();
      chk("R7 read after freeze", ready, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_plain8();
      t_plain9();
      t_par7();
      t_par8odd();
      t_overrun();
      t_idle();
      t_bad_frames();
      t_freeze();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule